// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

This block is a small sequential processor that keeps all of its working values on an internal last-in, first-out operand stack instead of in addressable registers. It reads one instruction per step from a synchronous instruction memory and talks to a byte-addressed data memory through a single read/write port. Only four operations exist. Two move words between memory and the stack. The other two combine the top two stack entries arithmetically.

A host loads a program into instruction memory and pulses `start`. The core then runs from instruction address zero with an empty stack. It stops and raises `halted` when it meets a reserved instruction word, runs off the end of instruction memory, or detects a stack fault. A stack fault also sets a sticky flag. A new `start` pulse clears the flags and the stack and runs the program again from address zero.

Top module: `stack_core`

## Requirements
- R1: LOAD (opcode bits [31:30] = 00) reads the data word at the byte address in instruction bits [15:0] and pushes it onto the stack.
- R2: STORE (opcode 01) pops the top stack entry and writes it to the byte address in instruction bits [15:0].
- R3: ADD (opcode 10) pops two entries and pushes their sum modulo 2^32. Instruction bits [15:0] have no effect on the result.
- R4: MULT (opcode 11) pops two entries and pushes the low 32 bits of their product.
- R5: The stack is strictly last-in, first-out, so LOAD a, LOAD b, STORE a, STORE b swaps the words at a and b.
- R6: An instruction word whose bits [29:16] are not all zero is reserved. It halts the core with both fault flags clear and makes no data-memory access.
- R7: A LOAD issued while the stack already holds 8 entries sets `fault_overflow` and halts the core without a data-memory read.
- R8: A STORE on an empty stack, or an ADD or MULT with fewer than two entries, sets `fault_underflow` and halts the core without a data-memory access.
- R9: Halt and the fault flags hold until `start`. A `start` pulse clears both flags, empties the stack and restarts execution at instruction address 0.
- R10: After the instruction at the last instruction-memory address (255) completes, the core halts with both fault flags clear.
- R11: After reset, `halted` and both fault flags are low, `imem_addr` is 0, and the core issues no memory access until `start`.
- R12: Every instruction takes exactly 4 clock cycles: fetch, decode, memory access, stack update. LOAD and STORE each raise their data-memory strobe for exactly one cycle. A reserved word halts 3 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin or restart execution from address 0 |
| imem_addr | output | 8 | Instruction word address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after its address |
| dmem_addr | output | 16 | Data byte address |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 32 | Data word to write |
| dmem_rdata | input | 32 | Data word read, valid one cycle after the read strobe |
| halted | output | 1 | Core stopped |
| fault_overflow | output | 1 | Sticky: push onto a full stack |
| fault_underflow | output | 1 | Sticky: pop from too few entries |

## Verification
The hardest condition to reach from the ports is a completely full stack followed by one more push. The core also has to show that a restart really empties the stack, because a leftover entry stays invisible until something pops it. Random programs are built by a generator that tracks the stack depth and pushes toward the limit, and a reference model runs the same program on a shadow memory. Directed programs add a ninth LOAD to get the overflow, and then restart with a lone STORE. That STORE must underflow and not write a stale value.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_MULT  = 2'b11
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_MEM, ST_EXEC, ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        SK_HOLD, SK_PUSH, SK_POP, SK_FOLD
    } stk_cmd_e;
endpackage

// File: rtl/stack_core_decode.sv
module stack_core_decode
    import stack_core_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int ADDR_W  = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output opcode_e            op,
    output logic [ADDR_W-1:0]  addr,
    output logic               reserved
);
    // Opcode in the two top bits, direct address in the low field,
    // everything in between must be zero.
    always_comb begin
        op       = opcode_e'(instr[INSTR_W-1 -: 2]);
        addr     = instr[ADDR_W-1:0];
        reserved = |instr[INSTR_W-3:ADDR_W];
    end
endmodule

// File: rtl/stack_core_alu.sv
module stack_core_alu
    import stack_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        prod = {{DATA_W{1'b0}}, lhs} * {{DATA_W{1'b0}}, rhs};
        if (op == OP_MULT) res = prod[DATA_W-1:0];
        else               res = lhs + rhs;
    end
endmodule

// File: rtl/stack_core_lifo.sv
module stack_core_lifo
    import stack_core_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 32,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_cmd_e          cmd,
    input  logic              clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CW-1:0]     count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     sp_d, sp_q;
    logic [IW-1:0]     waddr;
    logic              wen;

    always_comb begin
        sp_d  = sp_q;
        wen   = 1'b0;
        waddr = IW'(sp_q);
        unique case (cmd)
            SK_PUSH: begin sp_d = sp_q + CW'(1); wen = 1'b1; end
            SK_POP:  sp_d = sp_q - CW'(1);
            // Replace the second entry with the result and drop the top.
            SK_FOLD: begin
                sp_d  = sp_q - CW'(1);
                wen   = 1'b1;
                waddr = IW'(sp_q - CW'(2));
            end
            default: ;
        endcase
        if (clear) begin
            sp_d = '0;
            wen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
    end

    assign top    = mem[IW'(sp_q - CW'(1))];
    assign second = mem[IW'(sp_q - CW'(2))];
    assign count  = sp_q;
endmodule

// File: rtl/stack_core.sv
module stack_core
    import stack_core_pkg::*;
#(
    parameter  int DATA_W      = 32,
    parameter  int INSTR_W     = 32,
    parameter  int ADDR_W      = 16,
    parameter  int STACK_DEPTH = 8,
    parameter  int PROG_DEPTH  = 256,
    localparam int PC_W        = $clog2(PROG_DEPTH),
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]  dmem_addr,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               halted,
    output logic               fault_overflow,
    output logic               fault_underflow
);
    typedef struct packed {
        state_e             state;
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] ir;
        logic               ovf;
        logic               unf;
    } core_t;

    core_t              d, q;
    opcode_e            op;
    logic [ADDR_W-1:0]  op_addr;
    logic               op_reserved;
    stk_cmd_e           stk_cmd;
    logic               stk_clear;
    logic [DATA_W-1:0]  stk_wdata, stk_top, stk_second, alu_res;
    logic [CNT_W-1:0]   stk_count, need;
    logic               would_over, would_under;

    stack_core_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_decode (
        .instr(q.ir), .op(op), .addr(op_addr), .reserved(op_reserved)
    );

    stack_core_alu #(.DATA_W(DATA_W)) u_alu (
        .op(op), .lhs(stk_second), .rhs(stk_top), .res(alu_res)
    );

    stack_core_lifo #(.DEPTH(STACK_DEPTH), .DATA_W(DATA_W)) u_lifo (
        .clk(clk), .rst_n(rst_n), .cmd(stk_cmd), .clear(stk_clear),
        .wdata(stk_wdata), .top(stk_top), .second(stk_second), .count(stk_count)
    );

    always_comb begin
        d         = q;
        stk_cmd   = SK_HOLD;
        stk_clear = 1'b0;
        stk_wdata = alu_res;
        dmem_re   = 1'b0;
        dmem_we   = 1'b0;

        unique case (op)
            OP_LOAD:  need = CNT_W'(0);
            OP_STORE: need = CNT_W'(1);
            default:  need = CNT_W'(2);
        endcase
        would_over  = (op == OP_LOAD) && (stk_count == CNT_W'(STACK_DEPTH));
        would_under = stk_count < need;

        unique case (q.state)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    d.state   = ST_FETCH;
                    d.pc      = '0;
                    d.ovf     = 1'b0;
                    d.unf     = 1'b0;
                    stk_clear = 1'b1;
                end
            end
            ST_FETCH:  d.state = ST_DECODE;
            ST_DECODE: begin
                d.ir    = imem_rdata;
                d.state = ST_MEM;
            end
            ST_MEM: begin
                // Faults are judged before any strobe leaves the core.
                if (op_reserved) begin
                    d.state = ST_HALT;
                end else if (would_over) begin
                    d.ovf   = 1'b1;
                    d.state = ST_HALT;
                end else if (would_under) begin
                    d.unf   = 1'b1;
                    d.state = ST_HALT;
                end else begin
                    dmem_re = (op == OP_LOAD);
                    dmem_we = (op == OP_STORE);
                    d.state = ST_EXEC;
                end
            end
            ST_EXEC: begin
                unique case (op)
                    OP_LOAD: begin
                        stk_cmd   = SK_PUSH;
                        stk_wdata = dmem_rdata;
                    end
                    OP_STORE: stk_cmd = SK_POP;
                    default:  stk_cmd = SK_FOLD;
                endcase
                if (q.pc == PC_W'(PROG_DEPTH - 1)) begin
                    d.state = ST_HALT;
                end else begin
                    d.pc    = q.pc + PC_W'(1);
                    d.state = ST_FETCH;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.pc    <= '0;
            q.ir    <= '0;
            q.ovf   <= 1'b0;
            q.unf   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign imem_addr       = q.pc;
    assign dmem_addr       = op_addr;
    assign dmem_wdata      = stk_top;
    assign halted          = (q.state == ST_HALT);
    assign fault_overflow  = q.ovf;
    assign fault_underflow = q.unf;
endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            halted,
    input logic            dmem_re,
    input logic            dmem_we,
    input logic            fault_overflow,
    input logic            fault_underflow,
    input logic [PC_W-1:0] imem_addr
);
    // R12: one strobe kind at a time, each a single cycle
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_re && dmem_we));
    a_r12_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> !dmem_re);
    a_r12_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);
    // R6: a stopped core touches no data memory
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!dmem_re && !dmem_we));
    // R7 / R8: any fault flag implies the core is stopped
    a_r7_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_overflow || fault_underflow) |-> halted);
    // R9: flags and halt persist until start
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_overflow && !start) |=> fault_overflow);
    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_underflow && !start) |=> fault_underflow);
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(imem_addr)));
endmodule

bind stack_core stack_core_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
    .dmem_re(dmem_re), .dmem_we(dmem_we),
    .fault_overflow(fault_overflow), .fault_underflow(fault_underflow),
    .imem_addr(imem_addr)
);

// File: tb/stack_core_tb.sv
`timescale 1ns/1ps
module stack_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  imem_addr;
    logic [31:0] imem_rdata = '0;
    logic [15:0] dmem_addr;
    logic        dmem_re, dmem_we;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata = '0;
    logic        halted, fault_overflow, fault_underflow;

    logic [31:0] imem [256];
    logic [31:0] dmem [1024];
    int checks = 0;
    int errors = 0;
    int re_cnt = 0;
    int we_cnt = 0;
    int cyc;

    localparam logic [31:0] RSV = 32'h0001_0000;

    always #2.5 clk = ~clk;

    stack_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .halted(halted), .fault_overflow(fault_overflow),
        .fault_underflow(fault_underflow)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        if (dmem_re) begin
            dmem_rdata <= dmem[dmem_addr[11:2]];
            re_cnt = re_cnt + 1;
        end
        if (dmem_we) begin
            dmem[dmem_addr[11:2]] <= dmem_wdata;
            we_cnt = we_cnt + 1;
        end
    end

    function automatic logic [31:0] enc(input logic [1:0] op, input logic [15:0] a);
        return {op, 14'b0, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) imem[i] = RSV;
    endtask

    task automatic run(output int n);
        re_cnt = 0;
        we_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!halted && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c, e, v;
        logic [31:0] model [64];
        logic [31:0] stk [8];
        int sp, len, mism;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) dmem[i] = '0;
        clear_prog();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, idle without start
        @(negedge clk);
        chk("R11 halted", {31'b0, halted}, 32'd0);
        chk("R11 faults", {30'b0, fault_overflow, fault_underflow}, 32'd0);
        chk("R11 imem_addr", {24'b0, imem_addr}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R11 no access", re_cnt + we_cnt, 32'd0);

        // R3 R4 R12: A*B + C*D into 1000, ADD carries junk address bits
        for (int t = 0; t < 4; t++) begin
            clear_prog();
            a = $urandom(); b = $urandom(); c = $urandom(); e = $urandom();
            if (t == 0) begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
            dmem[251] = a; dmem[252] = b; dmem[253] = c; dmem[254] = e;
            imem[0] = enc(2'b00, 16'd1004); imem[1] = enc(2'b00, 16'd1008);
            imem[2] = enc(2'b11, 16'h0);    imem[3] = enc(2'b00, 16'd1012);
            imem[4] = enc(2'b00, 16'd1016); imem[5] = enc(2'b11, 16'h5A5A);
            imem[6] = enc(2'b10, $urandom()); imem[7] = enc(2'b01, 16'd1000);
            run(cyc);
            chk("R3 R4 expression", dmem[250], a * b + c * e);
            chk("R12 cycles", cyc, 32'd35);
            chk("R12 strobes", re_cnt * 16 + we_cnt, 32'd65);
            chk("R6 reserved no fault", {30'b0, fault_overflow, fault_underflow}, 32'd0);
        end

        // R5: swap through the stack
        clear_prog();
        a = $urandom(); b = $urandom();
        dmem[500] = a; dmem[501] = b;
        imem[0] = enc(2'b00, 16'd2000); imem[1] = enc(2'b00, 16'd2004);
        imem[2] = enc(2'b01, 16'd2000); imem[3] = enc(2'b01, 16'd2004);
        run(cyc);
        chk("R5 swap lo", dmem[500], b);
        chk("R5 swap hi", dmem[501], a);

        // R1 R2 R3 R4 R5: random legal programs against a reference model
        for (int t = 0; t < 40; t++) begin
            clear_prog();
            for (int i = 0; i < 64; i++) begin
                dmem[i] = $urandom();
                model[i] = dmem[i];
            end
            sp = 0;
            len = 4 + ($urandom() % 40);
            for (int p = 0; p < len; p++) begin
                int k, ad;
                k = $urandom() % 4;
                if (sp < 2 && k >= 2) k = 0;
                if (sp == 0) k = 0;
                if (sp == 8 && k == 0) k = 1 + ($urandom() % 3);
                if (t % 4 == 0 && sp < 8 && p < 10) k = 0;
                ad = $urandom() % 64;
                imem[p] = enc(k[1:0], 16'(ad * 4));
                case (k)
                    0: begin stk[sp] = model[ad]; sp++; end
                    1: begin sp--; model[ad] = stk[sp]; end
                    2: begin sp--; stk[sp-1] = stk[sp-1] + stk[sp]; end
                    default: begin sp--; stk[sp-1] = stk[sp-1] * stk[sp]; end
                endcase
            end
            run(cyc);
            mism = 0;
            for (int i = 0; i < 64; i++) if (dmem[i] !== model[i] && mism == 0) begin
                mism = 1;
                chk("R1 R2 random program", dmem[i], model[i]);
            end
            if (mism == 0) chk("R1 R2 random program", 32'd0, 32'd0);
            chk("R12 random cycles", cyc, 32'(4 * len + 3));
        end

        // R7: ninth push overflows, no ninth read
        clear_prog();
        for (int i = 0; i < 9; i++) imem[i] = enc(2'b00, 16'd0);
        run(cyc);
        chk("R7 overflow flag", {30'b0, fault_overflow, fault_underflow}, 32'd2);
        chk("R7 halted", {31'b0, halted}, 32'd1);
        chk("R7 reads", re_cnt, 32'd8);
        chk("R7 cycles", cyc, 32'd35);

        // R9: sticky while halted, then restart empties the stack
        repeat (5) @(negedge clk);
        chk("R9 sticky", {29'b0, halted, fault_overflow, fault_underflow}, 32'd6);
        clear_prog();
        imem[0] = enc(2'b01, 16'd8);
        dmem[2] = 32'h1234_5678;
        run(cyc);
        chk("R9 restart flags", {30'b0, fault_overflow, fault_underflow}, 32'd1);
        chk("R8 store empty no write", we_cnt, 32'd0);
        chk("R9 stale not written", dmem[2], 32'h1234_5678);

        // R8: binary operations with a single entry
        for (int t = 0; t < 2; t++) begin
            clear_prog();
            imem[0] = enc(2'b00, 16'd4);
            imem[1] = enc(t == 0 ? 2'b10 : 2'b11, 16'd0);
            imem[2] = enc(2'b01, 16'd12);
            run(cyc);
            chk("R8 underflow flag", {30'b0, fault_overflow, fault_underflow}, 32'd1);
            chk("R8 no further access", re_cnt * 16 + we_cnt, 32'd16);
        end

        // R10: run off the end of instruction memory
        v = $urandom();
        dmem[10] = v;
        dmem[11] = '0;
        for (int i = 0; i < 256; i++)
            imem[i] = (i % 2 == 0) ? enc(2'b00, 16'd40) : enc(2'b01, 16'd44);
        run(cyc);
        chk("R10 halted", {29'b0, halted, fault_overflow, fault_underflow}, 32'd4);
        chk("R10 cycles", cyc, 32'd1024);
        chk("R10 data", dmem[11], v);
        chk("R10 reads", re_cnt, 32'd128);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule